// File: doc/BRIEF.md
# Page Write-Protection and Key Controller

This block sits between the command decoder and the storage array of a small paged tag memory and judges every decoded command before anything is touched. The memory has `N_USER` user pages (eight by default), one configuration page directly above them and one key page above that. For each command the controller returns either a grant or an abort. When a granted command has to change storage, the controller also issues a single write request with the target page and the full word to store. Every abort comes with a pulse that tells the surrounding logic to fall back to its power-up read sequence.

The controller holds two flags of its own, and only the power-on reset clears them. The first records that a user-page write has succeeded. The second records that the correct key has been presented. Everything else is read from its inputs: the stored per-page lock bits, the two guard bits of the configuration page, the key-required option and the stored key word. Its requests loop back into those inputs through the memory.

The configuration page word is laid out as follows. Bits `[N_USER-1:0]` hold the user lock bits. Bit `N_USER` holds the configuration guard, bit `N_USER+1` holds the key guard and bit `N_USER+2` holds the key-required option. All higher bits are zero.

Top module: `pgprot_ctrl`

## Requirements
- R1: A command presented with `cmd_valid` high at a clock edge produces, right after the next edge, `dec_valid` high with exactly one of `dec_grant` and `dec_abort` high. `revert_pulse` equals `dec_abort`. `mem_we` is high only together with `dec_grant`, for one cycle at most per command. With no command, all of these outputs are low one cycle later.
- R2: The opcodes are 0 read, 1 write page, 2 write lock, 3 write configuration, 4 set key and 5 check key. Opcodes 6 and 7 are always aborted.
- R3: Write page is granted only for pages 0 to 6 whose lock bit is 0. Lock bit i (bit i of `lock_byte`) protects page i, and 1 means protected. Page 7 is treated as always locked. Pages 7 and above are always refused. A grant writes `cmd_data` to `cmd_page`.
- R4: A granted write lock writes page 8. The new lock field is the stored lock bits OR `cmd_data[7:0]` OR the page-7 bit, so no lock bit is ever cleared. The guard bits and the option bit are carried over unchanged.
- R5: Write lock is aborted unless a write page has been granted since the last reset.
- R6: Write lock and write configuration are aborted unless `cmd_data[31:16]` is 16'h5555, an alternating pattern whose most significant bit is 0.
- R7: Write configuration is aborted while the configuration guard is 1. When granted, it writes page 8 with the lock field unchanged and with `cmd_data[8]`, `cmd_data[9]` and `cmd_data[10]` copied, not ORed, into the configuration guard, key guard and key-required positions.
- R8: Set key is aborted while the key guard is 1. When granted, it writes `cmd_data` to page 9.
- R9: While `key_required` is 1 and no check key has been granted since reset, read, write page, write lock, write configuration and set key are all aborted.
- R10: Check key is granted exactly when `cmd_data` equals `key_word`. A grant sets the key flag, which stays set until reset, and a mismatch aborts. Check key never writes.
- R11: Read is granted for pages 0 to 8 and aborted for page 9 and above. Read never writes.
- R12: Under reset every output is low. Reset also clears the write flag and the key flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, synchronous |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_page | input | 4 | Target page index |
| cmd_data | input | 32 | Command data word |
| lock_byte | input | 8 | Stored user page lock bits |
| cfg_guard | input | 1 | Stored configuration guard bit |
| key_guard | input | 1 | Stored key guard bit |
| key_required | input | 1 | Stored option: commands need the key first |
| key_word | input | 32 | Stored key |
| dec_valid | output | 1 | Decision present |
| dec_grant | output | 1 | Command accepted |
| dec_abort | output | 1 | Command refused |
| revert_pulse | output | 1 | Return to the power-up read sequence |
| mem_we | output | 1 | Memory write request |
| mem_page | output | 4 | Page to write |
| mem_wdata | output | 32 | Word to write |

## Verification
Every result is due after the first clock edge that follows the one sampling `cmd_valid`: the decision, the revert pulse, the write request and its page and data all come from one register stage. Both flags take their new value at that same edge, so they already affect the next command. The bench drives a command on a falling edge, reads all outputs on the next falling edge, and then confirms on the falling edge after that that every output has dropped. It holds its expected flags and the stored words in its own variables and copies granted writes back into the memory inputs, so that the OR-merge and the no-clear rule act on the values that were really written.

// File: rtl/pgprot_pkg.sv
// Package pgprot_pkg
// Shared opcode values and the per-command verdict used by the page
// protection controller. Assumes a 3-bit opcode field.
package pgprot_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_READ   = 3'd0;
    localparam logic [OP_W-1:0] OP_WRPAGE = 3'd1;
    localparam logic [OP_W-1:0] OP_WRLOCK = 3'd2;
    localparam logic [OP_W-1:0] OP_WRCFG  = 3'd3;
    localparam logic [OP_W-1:0] OP_SETKEY = 3'd4;
    localparam logic [OP_W-1:0] OP_CHKKEY = 3'd5;

    // Verdict for one command, produced combinationally
    typedef struct packed {
        logic grant;     // command may run
        logic we;        // command writes memory
        logic set_wrote; // a user page write succeeded
        logic set_key;   // key check succeeded
    } pg_verdict_t;

endpackage

// File: rtl/pgprot_pattern_chk.sv
// Module pgprot_pattern_chk
// Checks that the top CHK_W bits of a data word carry the alternating
// check pattern whose most significant bit is 0 (0101...).
// Assumes CHK_W <= DATA_W. Purely combinational.
module pgprot_pattern_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 16
) (
    input  logic [DATA_W-1:0] data,
    output logic              ok
);

    logic [CHK_W-1:0] expect_v;

    // Build the expected pattern bit by bit from the MSB down
    for (genvar k = 0; k < CHK_W; k++) begin : g_pat
        assign expect_v[CHK_W-1-k] = 1'(k % 2);
    end

    // Compare the check field with the pattern
    assign ok = (data[DATA_W-1 -: CHK_W] == expect_v);

endmodule

// File: rtl/pgprot_auth_state.sv
// Module pgprot_auth_state
// Holds the two sticky flags: a user-page write has succeeded, and the
// correct key has been presented. Only the power-on reset clears them.
// Assumes the set inputs are already qualified by a valid command.
module pgprot_auth_state (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wrote,
    input  logic set_key,
    output logic wrote_ok,
    output logic key_ok
);

    // Sticky flags, set once and held until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_ok <= 1'b0;
            key_ok   <= 1'b0;
        end else begin
            if (set_wrote) wrote_ok <= 1'b1;
            if (set_key)   key_ok   <= 1'b1;
        end
    end

endmodule

// File: rtl/pgprot_rule_eval.sv
// Module pgprot_rule_eval
// Combinational rule set: decides whether a command may run and, if it
// writes, which page and word to write. Configuration word layout:
// [N_USER-1:0] lock bits, N_USER config guard, N_USER+1 key guard,
// N_USER+2 key required. Assumes CHK_W + N_USER + 3 <= DATA_W and that
// the page index can address N_USER+2 pages.
module pgprot_rule_eval
    import pgprot_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAGE_W    = 4,
    parameter int N_USER    = 8,
    parameter int CHK_W     = 16,
    parameter int FIXED_PG  = 7
) (
    input  logic [OP_W-1:0]   op,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] data,
    input  logic [N_USER-1:0] lock_byte,
    input  logic              cfg_guard,
    input  logic              key_guard,
    input  logic              key_required,
    input  logic [DATA_W-1:0] key_word,
    input  logic              wrote_ok,
    input  logic              key_ok,
    output pg_verdict_t       verdict,
    output logic [PAGE_W-1:0] wpage,
    output logic [DATA_W-1:0] wdata
);

    localparam int UIDX_W = (N_USER > 1) ? $clog2(N_USER) : 1;
    localparam logic [PAGE_W-1:0] CFG_PG = PAGE_W'(N_USER);
    localparam logic [PAGE_W-1:0] KEY_PG = PAGE_W'(N_USER + 1);
    localparam int CG_BIT = N_USER;
    localparam int KG_BIT = N_USER + 1;
    localparam int KR_BIT = N_USER + 2;

    logic [N_USER-1:0] eff_lock;
    logic              pat_ok;
    logic              gate_ok;
    logic              user_hit;
    logic              page_locked;
    logic [DATA_W-1:0] lock_word;
    logic [DATA_W-1:0] cfg_word;

    // Effective lock bits: the fixed page is always protected
    for (genvar i = 0; i < N_USER; i++) begin : g_lock
        if (i == FIXED_PG) begin : g_fixed
            assign eff_lock[i] = 1'b1;
        end else begin : g_plain
            assign eff_lock[i] = lock_byte[i];
        end
    end

    pgprot_pattern_chk #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W)
    ) u_pat (
        .data (data),
        .ok   (pat_ok)
    );

    assign gate_ok     = !key_required || key_ok;
    assign user_hit    = (page < CFG_PG);
    assign page_locked = eff_lock[page[UIDX_W-1:0]];

    // Merged lock word: OR of old and new lock bits, guards carried over
    always_comb begin
        lock_word                 = '0;
        lock_word[N_USER-1:0]     = eff_lock | data[N_USER-1:0];
        lock_word[CG_BIT]         = cfg_guard;
        lock_word[KG_BIT]         = key_guard;
        lock_word[KR_BIT]         = key_required;
    end

    // Configuration word: lock bits kept, special bits replaced
    always_comb begin
        cfg_word                  = '0;
        cfg_word[N_USER-1:0]      = lock_byte;
        cfg_word[CG_BIT]          = data[CG_BIT];
        cfg_word[KG_BIT]          = data[KG_BIT];
        cfg_word[KR_BIT]          = data[KR_BIT];
    end

    // Per-opcode permission rules
    always_comb begin
        verdict = '0;
        wpage   = '0;
        wdata   = '0;
        case (op)
            OP_READ: begin
                verdict.grant = gate_ok && (page <= CFG_PG);
            end
            OP_WRPAGE: begin
                verdict.grant     = gate_ok && user_hit && !page_locked;
                verdict.we        = verdict.grant;
                verdict.set_wrote = verdict.grant;
                if (verdict.grant) begin
                    wpage = page;
                    wdata = data;
                end
            end
            OP_WRLOCK: begin
                verdict.grant = gate_ok && pat_ok && wrote_ok;
                verdict.we    = verdict.grant;
                if (verdict.grant) begin
                    wpage = CFG_PG;
                    wdata = lock_word;
                end
            end
            OP_WRCFG: begin
                verdict.grant = gate_ok && pat_ok && !cfg_guard;
                verdict.we    = verdict.grant;
                if (verdict.grant) begin
                    wpage = CFG_PG;
                    wdata = cfg_word;
                end
            end
            OP_SETKEY: begin
                verdict.grant = gate_ok && !key_guard;
                verdict.we    = verdict.grant;
                if (verdict.grant) begin
                    wpage = KEY_PG;
                    wdata = data;
                end
            end
            OP_CHKKEY: begin
                verdict.grant   = (data == key_word);
                verdict.set_key = verdict.grant;
            end
            default: begin
                verdict = '0;
            end
        endcase
    end

endmodule

// File: rtl/pgprot_ctrl.sv
// Module pgprot_ctrl
// Top of the page write-protection and key controller. Evaluates each
// decoded command against the stored protection state, registers the
// verdict and the write request one clock after cmd_valid, and pulses
// revert_pulse on every abort. Assumes one command per valid cycle.
module pgprot_ctrl
    import pgprot_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 4,
    parameter int N_USER   = 8,
    parameter int CHK_W    = 16,
    parameter int FIXED_PG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [N_USER-1:0] lock_byte,
    input  logic              cfg_guard,
    input  logic              key_guard,
    input  logic              key_required,
    input  logic [DATA_W-1:0] key_word,
    output logic              dec_valid,
    output logic              dec_grant,
    output logic              dec_abort,
    output logic              revert_pulse,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [DATA_W-1:0] mem_wdata
);

    pg_verdict_t       verdict;
    logic [PAGE_W-1:0] wpage;
    logic [DATA_W-1:0] wdata;
    logic              wrote_ok;
    logic              key_ok;

    pgprot_rule_eval #(
        .DATA_W   (DATA_W),
        .PAGE_W   (PAGE_W),
        .N_USER   (N_USER),
        .CHK_W    (CHK_W),
        .FIXED_PG (FIXED_PG)
    ) u_rules (
        .op           (cmd_op),
        .page         (cmd_page),
        .data         (cmd_data),
        .lock_byte    (lock_byte),
        .cfg_guard    (cfg_guard),
        .key_guard    (key_guard),
        .key_required (key_required),
        .key_word     (key_word),
        .wrote_ok     (wrote_ok),
        .key_ok       (key_ok),
        .verdict      (verdict),
        .wpage        (wpage),
        .wdata        (wdata)
    );

    pgprot_auth_state u_auth (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wrote (cmd_valid && verdict.set_wrote),
        .set_key   (cmd_valid && verdict.set_key),
        .wrote_ok  (wrote_ok),
        .key_ok    (key_ok)
    );

    // Decision register: one verdict per valid command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_grant    <= 1'b0;
            dec_abort    <= 1'b0;
            revert_pulse <= 1'b0;
        end else begin
            dec_valid    <= cmd_valid;
            dec_grant    <= cmd_valid && verdict.grant;
            dec_abort    <= cmd_valid && !verdict.grant;
            revert_pulse <= cmd_valid && !verdict.grant;
        end
    end

    // Write request register: page and word only with a granted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_page  <= '0;
            mem_wdata <= '0;
        end else if (cmd_valid && verdict.we) begin
            mem_we    <= 1'b1;
            mem_page  <= wpage;
            mem_wdata <= wdata;
        end else begin
            mem_we    <= 1'b0;
            mem_page  <= '0;
            mem_wdata <= '0;
        end
    end

endmodule

// Module pgprot_ctrl_chk
// Property checker for pgprot_ctrl. Keeps its own shadow flags of the
// write and key history, built from the output ports only.
module pgprot_ctrl_chk
    import pgprot_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 4,
    parameter int N_USER   = 8,
    parameter int FIXED_PG = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [PAGE_W-1:0] cmd_page,
    input logic [DATA_W-1:0] cmd_data,
    input logic [N_USER-1:0] lock_byte,
    input logic              cfg_guard,
    input logic              key_guard,
    input logic              key_required,
    input logic [DATA_W-1:0] key_word,
    input logic              dec_valid,
    input logic              dec_grant,
    input logic              dec_abort,
    input logic              mem_we,
    input logic [PAGE_W-1:0] mem_page,
    input logic [DATA_W-1:0] mem_wdata
);

    localparam int UIDX_W = (N_USER > 1) ? $clog2(N_USER) : 1;
    localparam logic [PAGE_W-1:0] CFG_PG = PAGE_W'(N_USER);
    localparam logic [PAGE_W-1:0] KEY_PG = PAGE_W'(N_USER + 1);
    localparam logic [PAGE_W-1:0] FIX_PG = PAGE_W'(FIXED_PG);

    logic seen_write_q, key_seen_q, last_chk_q;
    logic seen_write, key_seen, tgt_locked;

    assign seen_write = seen_write_q || (mem_we && mem_page < CFG_PG);
    assign key_seen   = key_seen_q || (dec_grant && last_chk_q);
    assign tgt_locked = (cmd_page < CFG_PG) &&
                        ((cmd_page == FIX_PG) || lock_byte[cmd_page[UIDX_W-1:0]]);

    // Shadow history of granted user writes and key checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_write_q <= 1'b0;
            key_seen_q   <= 1'b0;
            last_chk_q   <= 1'b0;
        end else begin
            seen_write_q <= seen_write;
            key_seen_q   <= key_seen;
            last_chk_q   <= cmd_valid && (cmd_op == OP_CHKKEY);
        end
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> dec_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!dec_valid && !mem_we));
    a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_grant != dec_abort));
    a_r1_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> dec_grant);
    a_r2_illegal_op: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op > OP_CHKKEY) |=> dec_abort);
    a_r3_locked_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRPAGE && tgt_locked) |=> (dec_abort && !mem_we));
    a_r4_lock_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRLOCK) |=>
        (!mem_we || ((mem_wdata[N_USER-1:0] & $past(lock_byte)) == $past(lock_byte))));
    a_r5_lock_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRLOCK && !seen_write) |=> dec_abort);
    a_r7_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRCFG && cfg_guard) |=> dec_abort);
    a_r8_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SETKEY && key_guard) |=> dec_abort);
    a_r9_key_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && key_required && !key_seen && cmd_op <= OP_SETKEY) |=> dec_abort);
    a_r10_key_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CHKKEY && cmd_data != key_word) |=> dec_abort);
    a_r11_key_page_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && cmd_page >= KEY_PG) |=> dec_abort);

endmodule

bind pgprot_ctrl pgprot_ctrl_chk #(
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .N_USER   (N_USER),
    .FIXED_PG (FIXED_PG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_page     (cmd_page),
    .cmd_data     (cmd_data),
    .lock_byte    (lock_byte),
    .cfg_guard    (cfg_guard),
    .key_guard    (key_guard),
    .key_required (key_required),
    .key_word     (key_word),
    .dec_valid    (dec_valid),
    .dec_grant    (dec_grant),
    .dec_abort    (dec_abort),
    .mem_we       (mem_we),
    .mem_page     (mem_page),
    .mem_wdata    (mem_wdata)
);

// File: tb/pgprot_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for pgprot_ctrl: acts as the memory behind the controller and
// sweeps opcodes, pages, lock values and pattern faults.
module pgprot_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_page = '0;
    logic [31:0] cmd_data = '0;
    logic [7:0]  lock_byte = '0;
    logic        cfg_guard = 1'b0;
    logic        key_guard = 1'b0;
    logic        key_required = 1'b1;
    logic [31:0] key_word = 32'hC3A5_0F96;
    logic        dec_valid, dec_grant, dec_abort, revert_pulse, mem_we;
    logic [3:0]  mem_page;
    logic [31:0] mem_wdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  b_wrote = 0;
    bit  b_key = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    pgprot_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_page (cmd_page), .cmd_data (cmd_data), .lock_byte (lock_byte),
        .cfg_guard (cfg_guard), .key_guard (key_guard),
        .key_required (key_required), .key_word (key_word),
        .dec_valid (dec_valid), .dec_grant (dec_grant), .dec_abort (dec_abort),
        .revert_pulse (revert_pulse), .mem_we (mem_we), .mem_page (mem_page),
        .mem_wdata (mem_wdata)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Drive one command, check its verdict and the idle cycle after it
    task automatic issue(input logic [2:0] op, input logic [3:0] pg,
                         input logic [31:0] d, input string req);
        bit eg, ewe, gate, pat;
        logic [3:0]  ep;
        logic [31:0] ed;
        gate = key_required && !b_key;
        pat  = (d[31:16] == 16'h5555);
        eg = 0; ewe = 0; ep = '0; ed = '0;
        case (op)
            3'd0: eg = !gate && (pg <= 4'd8);
            3'd1: begin
                eg = !gate && (pg < 4'd7) && !lock_byte[pg[2:0]];
                ewe = eg; ep = pg; ed = d;
            end
            3'd2: begin
                eg = !gate && pat && b_wrote;
                ewe = eg; ep = 4'd8;
                ed = {21'd0, key_required, key_guard, cfg_guard, lock_byte | d[7:0] | 8'h80};
            end
            3'd3: begin
                eg = !gate && pat && !cfg_guard;
                ewe = eg; ep = 4'd8;
                ed = {21'd0, d[10], d[9], d[8], lock_byte};
            end
            3'd4: begin
                eg = !gate && !key_guard;
                ewe = eg; ep = 4'd9; ed = d;
            end
            3'd5: eg = (d == key_word);
            default: eg = 0;
        endcase
        if (!ewe) begin ep = '0; ed = '0; end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_data = d;
        @(negedge clk);
        check(dec_valid && dec_grant == eg && dec_abort == !eg && revert_pulse == !eg
              && mem_we == ewe && mem_page == ep && mem_wdata == ed, req,
              $sformatf("op%0d pg%0d v%b g%b a%b r%b we%b p%0d d%h", op, pg, dec_valid,
                        dec_grant, dec_abort, revert_pulse, mem_we, mem_page, mem_wdata),
              $sformatf("v1 g%b a%b r%b we%b p%0d d%h", eg, !eg, !eg, ewe, ep, ed));
        cmd_valid = 1'b0;
        if (eg && op == 3'd1) b_wrote = 1;
        if (eg && op == 3'd5) b_key = 1;
        if (ewe && ep == 4'd8) begin
            lock_byte = ed[7:0]; cfg_guard = ed[8]; key_guard = ed[9]; key_required = ed[10];
        end
        if (ewe && ep == 4'd9) key_word = ed;
        @(negedge clk);
        check(!dec_valid && !dec_grant && !dec_abort && !revert_pulse && !mem_we, "R1",
              $sformatf("idle v%b g%b a%b r%b we%b", dec_valid, dec_grant, dec_abort,
                        revert_pulse, mem_we), "all low");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!dec_valid && !dec_grant && !dec_abort && !revert_pulse && !mem_we
              && mem_page == 0 && mem_wdata == 0, "R12",
              $sformatf("v%b g%b a%b we%b", dec_valid, dec_grant, dec_abort, mem_we), "all zero");
        b_wrote = 0; b_key = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: key required and not yet presented
        for (int op = 0; op < 5; op++) issue(3'(op), 4'd1, 32'h5555_0001, "R9");
        // R10: wrong then correct key
        issue(3'd5, 4'd0, 32'h0BAD_0BAD, "R10");
        issue(3'd5, 4'd0, key_word, "R10");
        // R11: reads across the whole page index range
        for (int pg = 0; pg < 16; pg++) issue(3'd0, 4'(pg), 32'h0, "R11");
        // R2: illegal opcodes
        issue(3'd6, 4'd0, 32'h0, "R2");
        issue(3'd7, 4'd3, 32'h5555_0000, "R2");
        // R5: write lock before any page write
        issue(3'd2, 4'd0, 32'h5555_0001, "R5");
        // R3: page writes under several lock patterns
        for (int v = 0; v < 256; v += 51) begin
            lock_byte = 8'(v);
            for (int pg = 0; pg < 16; pg++)
                issue(3'd1, 4'(pg), {8'(v), 20'h0, 4'(pg)}, "R3");
        end
        lock_byte = 8'h30;
        // R6: every single-bit fault in the check field
        for (int b = 16; b < 32; b++) begin
            issue(3'd2, 4'd0, 32'h5555_000F ^ (32'd1 << b), "R6");
            issue(3'd3, 4'd0, 32'h5555_0400 ^ (32'd1 << b), "R6");
        end
        // R4: OR merge, no clearing
        issue(3'd2, 4'd0, 32'h5555_000F, "R4");
        issue(3'd2, 4'd0, 32'h5555_0000, "R4");
        issue(3'd1, 4'd2, 32'h1111_2222, "R4");
        // R8: change key and present it
        issue(3'd4, 4'd9, 32'h1357_9BDF, "R8");
        issue(3'd5, 4'd0, 32'h1357_9BDF, "R8");
        // R7: set key guard, then config guard, then refused
        issue(3'd3, 4'd8, 32'h5555_0600, "R7");
        issue(3'd4, 4'd9, 32'h2468_ACE0, "R8");
        issue(3'd3, 4'd8, 32'h5555_0500, "R7");
        issue(3'd3, 4'd8, 32'h5555_0600, "R7");
        issue(3'd4, 4'd9, 32'h2468_ACE0, "R8");
        // R12: flags cleared by reset
        do_reset();
        issue(3'd2, 4'd0, 32'h5555_0001, "R12");
        issue(3'd0, 4'd0, 32'h0, "R12");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule